// File: doc/BRIEF.md
# Two-wire TCLK burst generator

This block sends a burst of TCLK half-cycles to a debug target over a two-wire link. The link has one clock line and one shared bidirectional data line. The target's flash controller needs TCLK pulses. Here they are carried as level changes on the data line, placed inside one long clock-high phase. The target's TAP therefore never leaves Run-Test/Idle during the burst.

A burst runs in three slots:
- A TMS slot that drives TMS low. In its low phase the data line is preset to the previous TCLK level.
- A stretched TDI slot. The clock stays high for the whole slot, and each TCLK half-cycle puts one stream bit on the data line for a fixed number of ticks.
- A TDO slot. The line is released in this slot.

The caller supplies three things: the half-cycle count minus one, the TCLK level left by the last burst, and a byte stream of level values. Two stream patterns are typical. Alternating patterns (`0x55`, `0xAA`) give strobes. A count of zero with `0x00` or `0xFF` gives a single clear or set.

All durations are counted in ticks. A tick is `DIV` clocks. The clock-line rate is chosen through `DIV`, and the intended TCLK range is 250 to 450 kHz.

Top module: `tclk_burst_gen`

## Requirements
- R1: While idle, `tck_o` is 1, `tdio_oe_o` is 0, `tdio_o` is 0, `busy_o` is 0 and `byte_ready_o` is 0. This is also the state after reset.
- R2: `start_i` is taken only when idle. On that cycle `half_cnt_i` and `prev_lvl_i` are captured. A `start_i` pulse during a burst has no effect on the waveform.
- R3: The first tick after a start drives `tck_o`=1 with data 0 (TMS low). Then `tck_o` is 0 for 2 ticks: data is 0 in the first tick and the captured previous level in the second.
- R4: `tck_o` then stays 1 for the whole TDI slot. The data line first holds the previous level for `HALF_TICKS` (13) ticks. Each TCLK half-cycle then holds one stream bit for 13 ticks.
- R5: The number of half-cycles is `half_cnt_i`+1.
- R6: Stream bits are used most-significant bit first, 8 per byte. `byte_ready_o` is 1 exactly on a cycle in which the byte on `byte_i` is taken. After a burst, exactly ceil((`half_cnt_i`+1)/8) bytes have been taken.
- R7: Bits left over from a partly used byte are discarded when a new burst starts. The next burst begins on a fresh byte.
- R8: If no bit is available when a half-cycle should start, the block waits. During the wait `tck_o` stays 1, the data line holds its level and the output is still driven. The burst resumes as soon as a byte arrives.
- R9: After the last half-cycle:
  - `tck_o` is 0 for 2 ticks with data still driven.
  - Then the line is released (`tdio_oe_o`=0) while `tck_o` is 1 for 2 ticks and 0 for 2 ticks.
  - Then the block is idle.
- R10: `last_lvl_o` takes the level of the final half-cycle when the burst leaves the TDI slot. It holds that value until the next burst ends.
- R11: With a count of 0, byte `0xFF` gives a single set and `0x00` gives a single clear. With a count of 7, `0x55` and `0xAA` give alternating strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a burst (taken when idle) |
| half_cnt_i | input | CNT_W | Number of TCLK half-cycles minus one |
| prev_lvl_i | input | 1 | TCLK level left by the previous burst |
| byte_valid_i | input | 1 | A stream byte is offered |
| byte_i | input | 8 | Stream byte, MSB used first |
| byte_ready_o | output | 1 | Offered byte is taken this cycle |
| tck_o | output | 1 | Link clock line |
| tdio_o | output | 1 | Link data line value |
| tdio_oe_o | output | 1 | Link data line drive enable |
| busy_o | output | 1 | Burst in progress |
| last_lvl_o | output | 1 | TCLK level at the end of the last burst |

## Verification
The hardest situation to reach is a stream underrun in the middle of a burst that needs more than one byte. The wait must keep the clock high and the data level frozen, and the burst must then resume with the correct bit timing.

The bench reaches it as follows:
- It starts a ten-half-cycle burst with only one byte queued.
- It samples the lines well into the wait and again some cycles later.
- It then supplies the second byte and checks three things: the first resumed bit appears, the bit after it changes exactly one half-cycle later, and the final level is reported.

The discard of leftover bits is reached by a twelve-bit burst followed by a one-bit burst whose correct result differs from the leftover bits.

// File: rtl/tclk_burst_pkg.sv
package tclk_burst_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TMS_HI,
    ST_TMS_LO,
    ST_PRE,
    ST_BIT,
    ST_STALL,
    ST_FALL,
    ST_TDO_HI,
    ST_TDO_LO
  } phase_e;

  // Length of each phase in ticks; the half-cycle length is a parameter.
  function automatic int unsigned phase_ticks(phase_e p, int unsigned half);
    case (p)
      ST_TMS_LO, ST_FALL, ST_TDO_HI, ST_TDO_LO: return 2;
      ST_PRE, ST_BIT:                           return half;
      default:                                  return 1;
    endcase
  endfunction

  // Clock line level for a phase.
  function automatic logic phase_tck(phase_e p);
    return !(p == ST_TMS_LO || p == ST_FALL || p == ST_TDO_LO);
  endfunction

  // Whether the data line is driven in a phase.
  function automatic logic phase_oe(phase_e p);
    return (p != ST_IDLE) && (p != ST_TDO_HI) && (p != ST_TDO_LO);
  endfunction

  // Bytes needed for a given half-cycle field (count minus one).
  function automatic int unsigned bytes_needed(int unsigned cnt_m1, int unsigned bw);
    return (cnt_m1 + bw) / bw;
  endfunction

endpackage

// File: rtl/tclk_tick_gen.sv
module tclk_tick_gen #(
  parameter int unsigned DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DIV_W-1:0] div_q;

  assign tick_o = (div_q == DIV_W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tclk_bit_feeder.sv
module tclk_bit_feeder #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              take_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              avail_o,
  output logic              bit_o,
  output logic              ready_o
);
  localparam int unsigned LEFT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] sh_q;
  logic [LEFT_W-1:0] left_q;
  logic              empty_w;

  assign empty_w = (left_q == '0);
  assign avail_o = !empty_w || byte_valid_i;
  assign bit_o   = empty_w ? byte_i[BYTE_W-1] : sh_q[BYTE_W-1];
  assign ready_o = take_i && empty_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (clear_i) begin
      left_q <= '0;
    end else if (take_i) begin
      if (empty_w) begin
        sh_q   <= {byte_i[BYTE_W-2:0], 1'b0};
        left_q <= LEFT_W'(BYTE_W - 1);
      end else begin
        sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
        left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/tclk_burst_gen.sv
module tclk_burst_gen
  import tclk_burst_pkg::*;
#(
  parameter int unsigned HALF_TICKS = 13,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned DIV        = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] half_cnt_i,
  input  logic             prev_lvl_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  output logic             byte_ready_o,
  output logic             tck_o,
  output logic             tdio_o,
  output logic             tdio_oe_o,
  output logic             busy_o,
  output logic             last_lvl_o
);
  localparam int unsigned PH_W = $clog2(HALF_TICKS + 1);

  phase_e           state_q;
  logic [PH_W-1:0]  ph_q;
  logic [CNT_W-1:0] left_q;
  logic             prev_q, data_q, last_q;

  logic tick_w, avail_w, bit_w;
  logic accept_w, phase_end_w, want_bit_w, fetch_w, stall_w, tdi_slot_w;

  tclk_tick_gen #(.DIV(DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick_o(tick_w)
  );

  tclk_bit_feeder #(.BYTE_W(8)) feed_i (
    .clk(clk), .rst_n(rst_n), .clear_i(accept_w), .take_i(fetch_w),
    .byte_valid_i(byte_valid_i), .byte_i(byte_i),
    .avail_o(avail_w), .bit_o(bit_w), .ready_o(byte_ready_o)
  );

  assign accept_w    = tick_w && (state_q == ST_IDLE) && start_i;
  assign phase_end_w = tick_w && (32'(ph_q) + 1 >= phase_ticks(state_q, HALF_TICKS));
  assign want_bit_w  = (phase_end_w && (state_q == ST_PRE ||
                                        (state_q == ST_BIT && left_q != '0)))
                     || (tick_w && state_q == ST_STALL);
  assign fetch_w     = want_bit_w && avail_w;
  assign stall_w     = (state_q == ST_STALL);
  assign tdi_slot_w  = (state_q == ST_PRE) || (state_q == ST_BIT) || stall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      left_q  <= '0;
      prev_q  <= 1'b0;
      data_q  <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      if (tick_w) ph_q <= phase_end_w ? '0 : ph_q + 1'b1;
      if (fetch_w) begin
        data_q  <= bit_w;
        state_q <= ST_BIT;
      end
      case (state_q)
        ST_IDLE: if (accept_w) begin
          state_q <= ST_TMS_HI;
          left_q  <= half_cnt_i;
          prev_q  <= prev_lvl_i;
          data_q  <= 1'b0;
        end
        ST_TMS_HI: if (phase_end_w) state_q <= ST_TMS_LO;
        ST_TMS_LO: begin
          if (tick_w && ph_q == '0) data_q <= prev_q;
          if (phase_end_w) state_q <= ST_PRE;
        end
        ST_PRE: if (phase_end_w && !avail_w) state_q <= ST_STALL;
        ST_BIT: if (phase_end_w) begin
          if (left_q == '0) begin
            state_q <= ST_FALL;
            last_q  <= data_q;
          end else begin
            left_q <= left_q - 1'b1;
            if (!avail_w) state_q <= ST_STALL;
          end
        end
        ST_FALL:   if (phase_end_w) state_q <= ST_TDO_HI;
        ST_TDO_HI: if (phase_end_w) state_q <= ST_TDO_LO;
        ST_TDO_LO: if (phase_end_w) state_q <= ST_IDLE;
        default: ;
      endcase
    end
  end

  assign tck_o      = phase_tck(state_q);
  assign tdio_oe_o  = phase_oe(state_q);
  assign tdio_o     = data_q && tdio_oe_o;
  assign busy_o     = (state_q != ST_IDLE);
  assign last_lvl_o = last_q;
endmodule

// File: rtl/tclk_burst_checker.sv
module tclk_burst_checker (
  input logic clk,
  input logic rst_n,
  input logic tck,
  input logic tdio,
  input logic oe,
  input logic busy,
  input logic ready,
  input logic valid,
  input logic last_lvl,
  input logic stall,
  input logic tdi_slot,
  input logic fetch
);
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tck && !oe && !tdio && !ready));

  assert_tms_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> (tck && !tdio));

  assert_tdi_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tdi_slot |-> (tck && oe));

  assert_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (fetch && valid));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |-> ($stable(tdio) && tck));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> (tck && busy));

  assert_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $stable(last_lvl));
endmodule

bind tclk_burst_gen tclk_burst_checker chk_i (
  .clk(clk), .rst_n(rst_n), .tck(tck_o), .tdio(tdio_o), .oe(tdio_oe_o),
  .busy(busy_o), .ready(byte_ready_o), .valid(byte_valid_i),
  .last_lvl(last_lvl_o), .stall(stall_w), .tdi_slot(tdi_slot_w),
  .fetch(fetch_w)
);

// File: tb/tclk_burst_gen_tb_top.sv
module tclk_burst_gen_tb_top;
  localparam int HT = 13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] half_cnt_i = '0;
  logic       prev_lvl_i = 1'b0;
  logic       byte_valid_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       byte_ready_o, tck_o, tdio_o, tdio_oe_o, busy_o, last_lvl_o;

  always #5 clk = ~clk;

  tclk_burst_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_cnt_i(half_cnt_i),
    .prev_lvl_i(prev_lvl_i), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
    .byte_ready_o(byte_ready_o), .tck_o(tck_o), .tdio_o(tdio_o),
    .tdio_oe_o(tdio_oe_o), .busy_o(busy_o), .last_lvl_o(last_lvl_o)
  );

  typedef struct {
    logic  tck, oe, dat, busy;
    string tag;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] feed_q[$];
  int         total = 0, bad = 0;
  bit         done_flag = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // byte source
  initial begin
    forever begin
      bit xfer;
      @(negedge clk);
      xfer = byte_valid_i && byte_ready_o;
      @(posedge clk);
      #1;
      if (xfer) void'(feed_q.pop_front());
      byte_valid_i = (feed_q.size() > 0);
      byte_i       = (feed_q.size() > 0) ? feed_q[0] : 8'h00;
    end
  end

  // monitor: compare each cycle against the scoreboard
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(tck_o == e.tck && tdio_oe_o == e.oe && busy_o == e.busy &&
            tdio_o == (e.dat && e.oe), e.tag,
            {tck_o, tdio_oe_o, tdio_o, busy_o},
            {e.tck, e.oe, e.dat && e.oe, e.busy});
    end
  end

  task automatic push_n(input int n, input logic t, o, d, b, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.tck = t; e.oe = o; e.dat = d; e.busy = b; e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic run_burst(input int cnt, input bit prev, input logic [7:0] b0,
                           input logic [7:0] b1, input int nb, input bit poke);
    logic lvl;
    lvl = prev;
    @(negedge clk);
    feed_q.push_back(b0);
    if (nb > 1) feed_q.push_back(b1);
    start_i = 1; half_cnt_i = 8'(cnt); prev_lvl_i = prev;
    #1;
    push_n(1, 1, 1, 0, 1, "R3 tms high");
    push_n(1, 0, 1, 0, 1, "R3 tms low");
    push_n(1, 0, 1, prev, 1, "R3 preset");
    push_n(HT, 1, 1, prev, 1, "R4 pre-phase");
    for (int i = 0; i <= cnt; i++) begin
      logic [7:0] bb;
      bb  = (i / 8 == 0) ? b0 : b1;
      lvl = bb[7 - (i % 8)];
      push_n(HT, 1, 1, lvl, 1, "R4 R5 R6 R11 half-cycle");
    end
    push_n(2, 0, 1, lvl, 1, "R9 falling edge");
    push_n(2, 1, 0, 0, 1, "R9 tdo high");
    push_n(2, 0, 0, 0, 1, "R9 tdo low");
    push_n(1, 1, 0, 0, 0, "R1 R9 idle");
    @(posedge clk); #1; start_i = 0;
    if (poke) begin
      repeat (30) @(negedge clk);
      start_i = 1; half_cnt_i = 8'd3; prev_lvl_i = ~prev;
      @(posedge clk); #1; start_i = 0;
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
    check(last_lvl_o == lvl, "R10 final level", last_lvl_o, lvl);
    check(feed_q.size() == 0, "R6 bytes consumed", feed_q.size(), 0);
    check(!busy_o && !byte_ready_o, "R1 back idle", {busy_o, byte_ready_o}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tck_o && !tdio_oe_o && !busy_o && !byte_ready_o && !tdio_o, "R1 reset",
          {tck_o, tdio_oe_o, busy_o, byte_ready_o}, 4'b1000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(tck_o && !tdio_oe_o && !busy_o, "R1 idle after reset",
          {tck_o, tdio_oe_o, busy_o}, 3'b100);

    run_burst(0, 0, 8'hFF, 8'h00, 1, 0);  // R11 single set
    run_burst(0, 1, 8'h00, 8'h00, 1, 0);  // R11 single clear
    run_burst(7, 1, 8'h55, 8'h00, 1, 0);  // R11 strobes
    run_burst(7, 0, 8'hAA, 8'h00, 1, 1);  // R2 start ignored while busy
    run_burst(11, 0, 8'hA5, 8'h0F, 2, 0); // R6 two bytes, leftover 1111
    run_burst(0, 1, 8'h00, 8'h00, 1, 0);  // R7 leftover discarded -> 0

    // R8 underrun: ten half-cycles, only one byte present
    @(negedge clk);
    feed_q.push_back(8'hFF);
    start_i = 1; half_cnt_i = 8'd9; prev_lvl_i = 0;
    @(posedge clk); #1; start_i = 0;
    repeat (140) @(negedge clk);
    check(tck_o && tdio_oe_o && tdio_o && busy_o, "R8 stall lines",
          {tck_o, tdio_oe_o, tdio_o, busy_o}, 4'b1111);
    repeat (20) @(negedge clk);
    check(tck_o && tdio_oe_o && tdio_o && busy_o, "R8 stall held",
          {tck_o, tdio_oe_o, tdio_o, busy_o}, 4'b1111);
    feed_q.push_back(8'h40);
    for (int i = 0; i < 6 && tdio_o; i++) @(negedge clk);
    check(!tdio_o && tck_o, "R8 resume bit", tdio_o, 0);
    repeat (HT) @(negedge clk);
    check(tdio_o && tck_o, "R4 R8 next half-cycle", tdio_o, 1);
    for (int i = 0; i < 40 && busy_o; i++) @(negedge clk);
    check(!busy_o && last_lvl_o, "R10 after stall", {busy_o, last_lvl_o}, 1);
    check(feed_q.size() == 0, "R6 stall bytes consumed", feed_q.size(), 0);

    finish_run();
  end
endmodule